// File: doc/BRIEF.md
# Serial Pixel and Control Write Port

This block is the device side of the serial write port of a chainable LED dot-matrix display. A host drives a serial clock, a data line, a destination select and an active-low enable. While the enable is low, each rising serial clock edge shifts one bit into an internal shift chain. The select level is captured when the enable falls. When the enable returns high with the serial clock low, the chain contents move into one of two destinations: the pixel holding register, or one of two 7-bit control words.

Every serial input is oversampled by the block's own system clock. Edges are found by comparing each input with its value one cycle earlier. A serial output lets several displays be chained. It normally presents the last stage of the active chain. It can also be switched to a combinational pass-through, so that one control word reaches every display in the chain at once. An active-low reset clears both control words and leaves the pixel register untouched. A blank output combines the blank input with a sleep bit held in a control word.

Top module: `dotser_port`

## Requirements
- R1: A bit on `ser_din` enters stage 0 of the chain on each rising edge of `ser_clk` seen while `en_n` is low. Rising edges seen while `en_n` is high change nothing.
- R2: `reg_sel` is captured on the falling edge of `en_n` (0 = pixel register, 1 = control). Later changes to `reg_sel` during the same frame have no effect.
- R3: A rising edge of `en_n` with `ser_clk` low and pixel destination copies the whole chain into `dots_o`. The first bit shifted ends up in the MSB. The copy is visible one system clock after the edge.
- R4: A rising edge of `en_n` with `ser_clk` low and control destination takes the last 8 bits shifted, first bit as bit 7. If bit 7 is 0, bits 6..0 go to `ctrl_a_o`. If bit 7 is 1, they go to `ctrl_b_o`. The other control word keeps its value.
- R5: A rising edge of `en_n` while `ser_clk` is high transfers nothing. `dots_o`, `ctrl_a_o` and `ctrl_b_o` keep their values.
- R6: While `rst_n` is low, `ctrl_a_o` and `ctrl_b_o` are zero. This takes effect without a clock edge. `dots_o` keeps its value through reset.
- R7: With pixel destination, `ser_dout` is the last chain stage (bit DOT_BITS-1). With control destination, it is chain bit 7. When `ctrl_b_o` bit 0 is 1, the control destination is captured and `en_n` is low, `ser_dout` equals `ser_din` combinationally.
- R8: `blank_o` is high when `blank_in` is high or when `ctrl_a_o` bit 6 is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| ser_clk | input | 1 | Serial shift clock from the host |
| ser_din | input | 1 | Serial data from the host |
| reg_sel | input | 1 | Destination select: 0 pixel register, 1 control |
| en_n | input | 1 | Active-low frame enable |
| blank_in | input | 1 | Blank request; may be pulse-modulated for brightness |
| ser_dout | output | 1 | Cascade output to the next display |
| blank_o | output | 1 | Blank output to the driver stage |
| dots_o | output | DOT_BITS | Pixel holding register |
| ctrl_a_o | output | 7 | Control word written when bit 7 of the control byte is 0 |
| ctrl_b_o | output | 7 | Control word written when bit 7 of the control byte is 1; bit 0 enables pass-through |

## Verification
The assertions assume that the serial inputs are synchronous to `clk`. They also assume that each level of `ser_clk` and `en_n` is held for at least one system clock, so that every edge is seen exactly once. The bench changes its inputs only on the falling system clock edge, and it changes at most one of `ser_clk` and `en_n` per cycle. This means an enable rise never coincides with a serial clock edge. The bench also drives `ser_clk` high before the enable rises in the ignored-transfer case, so that case is tested under the same assumptions.

// File: rtl/dotser_pkg.sv
package dotser_pkg;
  localparam int CTRL_W       = 8;
  localparam int CTRL_FIELD_W = CTRL_W - 1;
  localparam int SLEEP_BIT    = 6;
  localparam int PASS_BIT     = 0;

  typedef enum logic {
    DEST_DOT  = 1'b0,
    DEST_CTRL = 1'b1
  } dest_e;
endpackage

// File: rtl/dotser_rst_sync.sv
module dotser_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/dotser_sample.sv
module dotser_sample #(
  parameter int          WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] lvl_q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q[g] <= RST_VAL[g];
      else        lvl_q[g] <= lvl_i[g];
    end
  end
endmodule

// File: rtl/dotser_shift.sv
module dotser_shift #(
  parameter int DOT_BITS = 160
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                din,
  output logic [DOT_BITS-1:0] sr_o
);
  logic [DOT_BITS-1:0] sr_q, sr_d;

  always_comb sr_d = {sr_q[DOT_BITS-2:0], din};

  always_ff @(posedge clk) begin
    if (shift_en) sr_q <= sr_d;
  end

  assign sr_o = sr_q;

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q[0] == $past(din));
  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> sr_q == $past(sr_q));
endmodule

// File: rtl/dotser_regs.sv
module dotser_regs
  import dotser_pkg::*;
#(
  parameter int DOT_BITS = 160
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  dest_e                   dest,
  input  logic [DOT_BITS-1:0]     sr,
  output logic [DOT_BITS-1:0]     dots_o,
  output logic [CTRL_FIELD_W-1:0] ctrl_a_o,
  output logic [CTRL_FIELD_W-1:0] ctrl_b_o
);
  logic [DOT_BITS-1:0]     dots_q;
  logic [CTRL_FIELD_W-1:0] ca_q, ca_d, cb_q, cb_d;
  logic                    dot_we, ctl_we, word_b;

  always_comb begin
    dot_we = load && (dest == DEST_DOT);
    ctl_we = load && (dest == DEST_CTRL);
    word_b = sr[CTRL_W-1];
    ca_d   = ca_q;
    cb_d   = cb_q;
    if (ctl_we) begin
      if (word_b) cb_d = sr[CTRL_FIELD_W-1:0];
      else        ca_d = sr[CTRL_FIELD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (dot_we) dots_q <= sr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca_q <= '0;
      cb_q <= '0;
    end else if (ctl_we) begin
      ca_q <= ca_d;
      cb_q <= cb_d;
    end
  end

  assign dots_o   = dots_q;
  assign ctrl_a_o = ca_q;
  assign ctrl_b_o = cb_q;

  // R3
  dot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && dest == DEST_DOT) |=> dots_q == $past(sr));
  // R4
  ctrl_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && dest == DEST_CTRL && !sr[CTRL_W-1]) |=>
      (ca_q == $past(sr[CTRL_FIELD_W-1:0])) && $stable(cb_q));
  // R6
  ctrl_reset_chk: assert property (@(posedge clk) disable iff (rst_n)
    (ca_q == '0) && (cb_q == '0));
endmodule

// File: rtl/dotser_port.sv
module dotser_port
  import dotser_pkg::*;
#(
  parameter int DOT_BITS = 160
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ser_clk,
  input  logic                    ser_din,
  input  logic                    reg_sel,
  input  logic                    en_n,
  input  logic                    blank_in,
  output logic                    ser_dout,
  output logic                    blank_o,
  output logic [DOT_BITS-1:0]     dots_o,
  output logic [CTRL_FIELD_W-1:0] ctrl_a_o,
  output logic [CTRL_FIELD_W-1:0] ctrl_b_o
);
  localparam int SCLK_IDX = 0;
  localparam int EN_IDX   = 1;
  localparam logic [1:0] LVL_RST = 2'b10;

  logic                rst_n_s;
  logic [1:0]          lvl_q;
  logic                sclk_rise, en_rise, en_fall;
  logic                shift_en, load;
  dest_e               sel_q, sel_d;
  logic [DOT_BITS-1:0] sr;

  dotser_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  dotser_sample #(.WIDTH(2), .RST_VAL(LVL_RST)) u_smp (
    .clk(clk), .rst_n(rst_n_s), .lvl_i({en_n, ser_clk}), .lvl_q(lvl_q));

  always_comb begin
    sclk_rise = ser_clk && !lvl_q[SCLK_IDX];
    en_rise   = en_n && !lvl_q[EN_IDX];
    en_fall   = !en_n && lvl_q[EN_IDX];
    shift_en  = sclk_rise && !en_n;
    load      = en_rise && !ser_clk;
    sel_d     = en_fall ? dest_e'(reg_sel) : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) sel_q <= DEST_DOT;
    else          sel_q <= sel_d;
  end

  dotser_shift #(.DOT_BITS(DOT_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .shift_en(shift_en), .din(ser_din), .sr_o(sr));

  dotser_regs #(.DOT_BITS(DOT_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .load(load), .dest(sel_q), .sr(sr),
    .dots_o(dots_o), .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o));

  always_comb begin
    if (sel_q == DEST_CTRL) begin
      if (ctrl_b_o[PASS_BIT] && !en_n) ser_dout = ser_din;
      else                             ser_dout = sr[CTRL_W-1];
    end else begin
      ser_dout = sr[DOT_BITS-1];
    end
  end

  assign blank_o = blank_in | ctrl_a_o[SLEEP_BIT];

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !en_fall |=> $stable(sel_q));
  // R2
  sel_capture_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    en_fall |=> sel_q == $past(reg_sel));
  // R5
  no_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (en_rise && ser_clk) |=>
      $stable(dots_o) && $stable(ctrl_a_o) && $stable(ctrl_b_o));
endmodule

// File: tb/dotser_port_bench.sv
module dotser_port_bench;
  localparam int DOT_BITS = 16;

  logic clk, rst_n, ser_clk, ser_din, reg_sel, en_n, blank_in;
  logic ser_dout, blank_o;
  logic [DOT_BITS-1:0] dots_o;
  logic [6:0] ctrl_a_o, ctrl_b_o;

  int checks = 0;
  int errors = 0;

  dotser_port #(.DOT_BITS(DOT_BITS)) u_dotser_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .reg_sel(reg_sel), .en_n(en_n), .blank_in(blank_in),
    .ser_dout(ser_dout), .blank_o(blank_o), .dots_o(dots_o),
    .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        sel;
    logic        hi;
    logic [15:0] data;
    logic [15:0] dots;
    logic [6:0]  ca;
    logic [6:0]  cb;
    logic        blank;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 1'b0, 16'hA5C3, 16'hA5C3, 7'h00, 7'h00, 1'b0},
    '{1'b1, 1'b0, 16'h0015, 16'hA5C3, 7'h15, 7'h00, 1'b0},
    '{1'b1, 1'b0, 16'h008A, 16'hA5C3, 7'h15, 7'h0A, 1'b0},
    '{1'b0, 1'b1, 16'h0F0F, 16'hA5C3, 7'h15, 7'h0A, 1'b0},
    '{1'b1, 1'b1, 16'h0033, 16'hA5C3, 7'h15, 7'h0A, 1'b0},
    '{1'b0, 1'b0, 16'h1234, 16'h1234, 7'h15, 7'h0A, 1'b0},
    '{1'b1, 1'b0, 16'h0040, 16'h1234, 7'h40, 7'h0A, 1'b1},
    '{1'b1, 1'b0, 16'h0000, 16'h1234, 7'h00, 7'h0A, 1'b0}
  };

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_din = b; ser_clk = 1'b0; tick();
    ser_clk = 1'b1; tick();
    ser_clk = 1'b0; tick();
  endtask

  task automatic write(input logic sel, input logic [15:0] data, input logic hi);
    int nb;
    nb = sel ? 8 : 16;
    reg_sel = sel; en_n = 1'b0; tick();
    for (int i = nb - 1; i >= 0; i--) shift_bit(data[i]);
    if (hi) begin
      ser_clk = 1'b1; tick();
      en_n = 1'b1; tick();
      ser_clk = 1'b0; tick();
    end else begin
      en_n = 1'b1; tick();
      tick();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] a_w, b_w, keep;
    rst_n = 1'b0; ser_clk = 1'b0; ser_din = 1'b0; reg_sel = 1'b0;
    en_n = 1'b1; blank_in = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R6 reset ctrl_a", 32'(ctrl_a_o), 32'h0);
    chk("R6 reset ctrl_b", 32'(ctrl_b_o), 32'h0);
    chk("R8 reset blank", 32'(blank_o), 32'h0);

    for (int v = 0; v < 8; v++) begin
      write(VEC[v].sel, VEC[v].data, VEC[v].hi);
      chk(VEC[v].hi ? "R5 dots" : "R3 dots", 32'(dots_o), 32'(VEC[v].dots));
      chk(VEC[v].hi ? "R5 ctrl_a" : "R4 ctrl_a", 32'(ctrl_a_o), 32'(VEC[v].ca));
      chk(VEC[v].hi ? "R5 ctrl_b" : "R4 ctrl_b", 32'(ctrl_b_o), 32'(VEC[v].cb));
      chk("R8 blank", 32'(blank_o), 32'(VEC[v].blank));
    end

    // R7 cascade and R1 idle clocks
    a_w = 16'hC3A5; b_w = 16'h3C69;
    write(1'b0, a_w, 1'b0);
    chk("R7 dout msb", 32'(ser_dout), 32'(a_w[15]));
    for (int k = 0; k < 3; k++) shift_bit(1'b0);
    chk("R1 idle clocks", 32'(ser_dout), 32'(a_w[15]));
    reg_sel = 1'b0; en_n = 1'b0; tick();
    for (int j = 1; j <= 16; j++) begin
      shift_bit(b_w[16 - j]);
      if (j < 16) chk("R7 cascade", 32'(ser_dout), 32'(a_w[15 - j]));
      else        chk("R7 cascade", 32'(ser_dout), 32'(b_w[15]));
    end
    en_n = 1'b1; tick(); tick();
    chk("R1 after idle", 32'(dots_o), 32'(b_w));

    // R2 select changed after enable fell
    reg_sel = 1'b0; en_n = 1'b0; tick();
    reg_sel = 1'b1;
    for (int i = 15; i >= 0; i--) shift_bit(logic'(16'h5A0F >> i));
    en_n = 1'b1; tick(); tick();
    chk("R2 dots", 32'(dots_o), 32'h5A0F);
    chk("R2 ctrl_a", 32'(ctrl_a_o), 32'h00);

    // R7 pass-through
    write(1'b1, 16'h0081, 1'b0);
    chk("R4 ctrl_b", 32'(ctrl_b_o), 32'h01);
    reg_sel = 1'b1; en_n = 1'b0; tick();
    ser_din = 1'b1; #1;
    chk("R7 pass 1", 32'(ser_dout), 32'h1);
    ser_din = 1'b0; #1;
    chk("R7 pass 0", 32'(ser_dout), 32'h0);
    en_n = 1'b1; tick(); tick();
    write(1'b1, 16'h0080, 1'b0);
    chk("R4 ctrl_b off", 32'(ctrl_b_o), 32'h00);
    reg_sel = 1'b1; en_n = 1'b0; tick();
    ser_din = 1'b0; tick();
    chk("R7 ctrl tap", 32'(ser_dout), 32'h1);
    en_n = 1'b1; tick(); tick();

    // R6 reset clears control, keeps dots
    write(1'b1, 16'h002A, 1'b0);
    write(1'b1, 16'h0085, 1'b0);
    chk("R4 ctrl_a", 32'(ctrl_a_o), 32'h2A);
    chk("R4 ctrl_b", 32'(ctrl_b_o), 32'h05);
    keep = dots_o;
    rst_n = 1'b0; #1;
    chk("R6 ctrl_a", 32'(ctrl_a_o), 32'h0);
    chk("R6 ctrl_b", 32'(ctrl_b_o), 32'h0);
    chk("R6 dots kept", 32'(dots_o), 32'(keep));
    tick(); tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R6 dots after", 32'(dots_o), 32'h5A0F);

    // R8 blank input
    blank_in = 1'b1; #1;
    chk("R8 blank in", 32'(blank_o), 32'h1);
    blank_in = 1'b0; #1;
    chk("R8 blank low", 32'(blank_o), 32'h0);

    summary();
    $finish;
  end
endmodule